// File: doc/BRIEF.md
# Dual Stack Pointer Sequencer

This block is the stack-control unit of a small 8-bit processor that owns 256 bytes of data RAM. It keeps two 8-bit pointers: a program-stack pointer, which subroutine calls, subroutine returns, interrupt entry and interrupt return use, and a data-stack pointer, which PUSH and POP use. The decoder issues one command at a time through a request port. The block then runs the single-port RAM accesses the command needs, updates the pointers, and pulses `done` when the command is complete.

The two stacks move in opposite directions. The program stack grows upward and writes before it increments. The data stack grows downward: it decrements before a write and increments after a read. A save packs the 14-bit program counter and the carry and zero flags into two bytes. The block also holds the interrupt-enable flag. Interrupt entry clears it and return from interrupt sets it.

Commands use `cmd_op`: 0 CALL, 1 RET, 2 RETI, 3 interrupt entry (IENT), 4 PUSH, 5 POP, 6 load program-stack pointer (LDP). The RAM reads synchronously, so read data appears on `ram_rdata` one cycle after `ram_re`.

Top module: `stack_seq`

## Requirements
- R1: After reset both pointers are 0, the interrupt-enable flag is 0, and `busy`, `done`, `ram_we` and `ram_re` are all 0.
- R2: CALL (0) and IENT (3) write the byte {carry, zero, pc[13:8]} (carry in bit 7, zero in bit 6) at the program-stack pointer P. They write pc[7:0] at P+1 and leave the pointer at P+2. `done` rises in the third cycle after the command is accepted.
- R3: IENT clears the interrupt-enable flag and RETI (2) sets it. The new value is visible from the cycle after `done`.
- R4: RET (1) reads pc[7:0] from P-1 and the flags/high byte from P-2, and leaves the pointer at P-2. It presents the program counter on `ret_pc` with `pc_load` high during `done`, which rises in the fourth cycle after the command is accepted. `flags_load` stays low.
- R5: RETI restores the program counter and the carry and zero flags from the same two bytes as RET. It asserts both `pc_load` and `flags_load` during `done`.
- R6: PUSH (4) first decrements the data-stack pointer D and then writes `cmd_data` at the new value. A PUSH with D = 0 writes address 0xFF. `done` rises in the second cycle after the command is accepted.
- R7: POP (5) reads the byte at D, increments D, and presents the byte on `pop_data` during `done`, which rises in the third cycle after the command is accepted.
- R8: LDP (6) loads the program-stack pointer from `cmd_data` without any RAM access. `done` rises in the first cycle after the command is accepted.
- R9: All pointer arithmetic wraps modulo 256. A save at P = 0xFF uses addresses 0xFF then 0x00, and a POP at D = 0xFF leaves D at 0.
- R10: `done` is a single-cycle pulse. Requests made while `busy` is high, and requests with op code 7, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request; accepted when not busy |
| cmd_op | input | 3 | Command code |
| cmd_pc | input | 14 | Program counter to save |
| cmd_carry | input | 1 | Carry flag to save |
| cmd_zero | input | 1 | Zero flag to save |
| cmd_data | input | 8 | PUSH data or new program-stack pointer |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| ram_addr | output | 8 | RAM address |
| ram_we | output | 1 | RAM write strobe |
| ram_wdata | output | 8 | RAM write data |
| ram_re | output | 1 | RAM read strobe |
| ram_rdata | input | 8 | RAM read data, one cycle after `ram_re` |
| ret_pc | output | 14 | Restored program counter |
| ret_carry | output | 1 | Restored carry flag |
| ret_zero | output | 1 | Restored zero flag |
| pc_load | output | 1 | `ret_pc` valid, with `done` |
| flags_load | output | 1 | Restored flags valid, with `done` |
| pop_data | output | 8 | Byte read by POP |
| int_en | output | 1 | Interrupt-enable flag |
| psp | output | 8 | Program-stack pointer |
| dsp | output | 8 | Data-stack pointer |

## Verification
The embedded assertions check the following on every cycle:
- `done` is a one-cycle pulse, and read and write strobes never occur together.
- A PUSH step lowers the data pointer by exactly one, and a program-stack write step raises the program pointer by one.
- An LDP lands the requested value.
- Interrupt entry leaves interrupts disabled.
- The restore strobes appear only with `done`.

Only the bench scenarios can show the rest: the byte layout in RAM, the restore order, the latencies, wrap-around at both ends of the address space, and requests ignored while busy.

// File: rtl/stack_seq.sv
module stack_seq #(
  parameter int PCW = 14,
  parameter int AW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_valid,
  input  logic [2:0]     cmd_op,
  input  logic [PCW-1:0] cmd_pc,
  input  logic           cmd_carry,
  input  logic           cmd_zero,
  input  logic [7:0]     cmd_data,
  output logic           busy,
  output logic           done,
  output logic [AW-1:0]  ram_addr,
  output logic           ram_we,
  output logic [7:0]     ram_wdata,
  output logic           ram_re,
  input  logic [7:0]     ram_rdata,
  output logic [PCW-1:0] ret_pc,
  output logic           ret_carry,
  output logic           ret_zero,
  output logic           pc_load,
  output logic           flags_load,
  output logic [7:0]     pop_data,
  output logic           int_en,
  output logic [AW-1:0]  psp,
  output logic [AW-1:0]  dsp
);
  localparam int HIW = PCW - 8;

  localparam logic [2:0] OP_CALL = 3'd0, OP_RET = 3'd1, OP_RETI = 3'd2,
                         OP_IENT = 3'd3, OP_PUSH = 3'd4, OP_POP = 3'd5,
                         OP_LDP  = 3'd6;

  typedef enum logic [3:0] {
    S_IDLE, S_W1, S_W2, S_RD2, S_RD1, S_CAP, S_PUSH, S_POP, S_DONE
  } state_t;

  state_t         st;
  logic [2:0]     op_q;
  logic [PCW-1:0] pc_q;
  logic           c_q, z_q;
  logic [7:0]     d_q;
  logic [7:0]     lo_q;
  logic [7:0]     hi_q;

  wire accept = (st == S_IDLE) && cmd_valid;

  assign busy  = (st != S_IDLE);
  assign done  = (st == S_DONE);
  assign ram_we = (st == S_W1) || (st == S_W2) || (st == S_PUSH);
  assign ram_re = (st == S_RD2) || (st == S_RD1) || (st == S_POP);

  always_comb begin
    case (st)
      S_W1, S_W2:   ram_addr = psp;
      S_RD2, S_RD1: ram_addr = psp - 1'b1;
      S_PUSH:       ram_addr = dsp - 1'b1;
      S_POP:        ram_addr = dsp;
      default:      ram_addr = '0;
    endcase
    case (st)
      S_W1:    ram_wdata = {c_q, z_q, pc_q[PCW-1:8]};
      S_W2:    ram_wdata = pc_q[7:0];
      S_PUSH:  ram_wdata = d_q;
      default: ram_wdata = '0;
    endcase
  end

  assign ret_pc     = {hi_q[HIW-1:0], lo_q};
  assign ret_carry  = hi_q[7];
  assign ret_zero   = hi_q[6];
  assign pc_load    = done && (op_q == OP_RET || op_q == OP_RETI);
  assign flags_load = done && (op_q == OP_RETI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      op_q     <= '0;
      pc_q     <= '0;
      c_q      <= 1'b0;
      z_q      <= 1'b0;
      d_q      <= '0;
      lo_q     <= '0;
      hi_q     <= '0;
      pop_data <= '0;
      int_en   <= 1'b0;
      psp      <= '0;
      dsp      <= '0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          op_q <= cmd_op;
          pc_q <= cmd_pc;
          c_q  <= cmd_carry;
          z_q  <= cmd_zero;
          d_q  <= cmd_data;
          case (cmd_op)
            OP_CALL, OP_IENT: st <= S_W1;
            OP_RET, OP_RETI:  st <= S_RD2;
            OP_PUSH:          st <= S_PUSH;
            OP_POP:           st <= S_POP;
            OP_LDP: begin
              psp <= cmd_data;
              st  <= S_DONE;
            end
            default:          st <= S_IDLE;
          endcase
        end
        S_W1: begin
          psp <= psp + 1'b1;
          st  <= S_W2;
        end
        S_W2: begin
          psp <= psp + 1'b1;
          st  <= S_DONE;
        end
        S_RD2: begin
          psp <= psp - 1'b1;
          st  <= S_RD1;
        end
        S_RD1: begin
          lo_q <= ram_rdata;
          psp  <= psp - 1'b1;
          st   <= S_CAP;
        end
        S_CAP: begin
          if (op_q == OP_POP) pop_data <= ram_rdata;
          else                hi_q     <= ram_rdata;
          st <= S_DONE;
        end
        S_PUSH: begin
          dsp <= dsp - 1'b1;
          st  <= S_DONE;
        end
        S_POP: begin
          dsp <= dsp + 1'b1;
          st  <= S_CAP;
        end
        S_DONE: begin
          if (op_q == OP_IENT) int_en <= 1'b0;
          if (op_q == OP_RETI) int_en <= 1'b1;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_we && ram_re)); // R10
  AST_PUSH_PREDEC: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PUSH) |=> dsp == $past(dsp) - 8'd1); // R6
  AST_PSP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_W2) |=> psp == $past(psp) + 8'd1); // R2
  AST_LDP_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cmd_op == OP_LDP) |=> psp == $past(cmd_data)); // R8
  AST_IENT_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q == OP_IENT) |=> !int_en); // R3
  AST_PC_LOAD_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> done); // R4
  AST_FLAGS_WITH_PC: assert property (@(posedge clk) disable iff (!rst_n)
    flags_load |-> pc_load); // R5
endmodule

// File: tb/stack_seq_test.sv
module stack_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic [13:0] cmd_pc = '0;
  logic        cmd_carry = 1'b0, cmd_zero = 1'b0;
  logic [7:0]  cmd_data = '0;
  logic        busy, done, ram_we, ram_re, pc_load, flags_load, int_en;
  logic        ret_carry, ret_zero;
  logic [7:0]  ram_addr, ram_wdata, pop_data, psp, dsp;
  logic [7:0]  ram_rdata = '0;
  logic [13:0] ret_pc;

  logic [7:0] mem [256];
  logic [7:0] smem [256];
  int m_psp = 0, m_dsp = 0, m_ie = 0;
  int tests = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  stack_seq uut (.*);

  always @(posedge clk) begin
    if (ram_we) mem[ram_addr] <= ram_wdata;
    if (ram_re) ram_rdata <= mem[ram_addr];
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !busy && !finished) begin
      chk(psp == m_psp[7:0], "R9 psp track", psp, m_psp);
      chk(dsp == m_dsp[7:0], "R9 dsp track", dsp, m_dsp);
      chk(int_en == m_ie[0], "R3 int_en track", int_en, m_ie);
    end
  end

  task automatic issue(input logic [2:0] op, input logic [13:0] pc, input bit c,
                       input bit z, input logic [7:0] d, input int exp_lat, input string req);
    int lat;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_pc = pc; cmd_carry = c; cmd_zero = z; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    lat = 1;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == exp_lat, req, lat, exp_lat);
  endtask

  task automatic after_done();
    @(negedge clk);
    chk(!done, "R10 done single pulse", done, 0);
  endtask

  task automatic do_save(input bit ient, input logic [13:0] pc, input bit c, input bit z);
    logic [7:0] b1, b2;
    int p;
    p = m_psp;
    b1 = {c, z, pc[13:8]};
    b2 = pc[7:0];
    issue(ient ? 3'd3 : 3'd0, pc, c, z, 8'h00, 3, "R2 save latency");
    chk(mem[p[7:0]] == b1, "R2 first byte", mem[p[7:0]], b1);
    chk(mem[(p+1) & 255] == b2, "R2 second byte", mem[(p+1) & 255], b2);
    smem[p[7:0]] = b1;
    smem[(p+1) & 255] = b2;
    m_psp = (p + 2) & 255;
    if (ient) m_ie = 0;
    after_done();
  endtask

  task automatic do_restore(input bit reti);
    logic [7:0] lo, hi;
    lo = smem[(m_psp - 1) & 255];
    hi = smem[(m_psp - 2) & 255];
    issue(reti ? 3'd2 : 3'd1, '0, 0, 0, 8'h00, 4, "R4 restore latency");
    chk(ret_pc == {hi[5:0], lo}, "R4 restored pc", ret_pc, {hi[5:0], lo});
    chk(pc_load == 1'b1, "R4 pc_load", pc_load, 1);
    chk(flags_load == reti, reti ? "R5 flags_load" : "R4 flags_load low", flags_load, reti);
    if (reti) begin
      chk(ret_carry == hi[7], "R5 carry", ret_carry, hi[7]);
      chk(ret_zero == hi[6], "R5 zero", ret_zero, hi[6]);
      m_ie = 1;
    end
    m_psp = (m_psp - 2) & 255;
    after_done();
  endtask

  task automatic do_push(input logic [7:0] d);
    int a;
    a = (m_dsp - 1) & 255;
    issue(3'd4, '0, 0, 0, d, 2, "R6 push latency");
    chk(mem[a[7:0]] == d, "R6 push address/data", mem[a[7:0]], d);
    smem[a[7:0]] = d;
    m_dsp = a;
    after_done();
  endtask

  task automatic do_pop();
    logic [7:0] e;
    e = smem[m_dsp[7:0]];
    issue(3'd5, '0, 0, 0, 8'h00, 3, "R7 pop latency");
    chk(pop_data == e, "R7 pop data", pop_data, e);
    m_dsp = (m_dsp + 1) & 255;
    after_done();
  endtask

  task automatic do_ldp(input logic [7:0] d);
    issue(3'd6, '0, 0, 0, d, 1, "R8 ldp latency");
    m_psp = d;
    after_done();
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'h00;
      smem[i] = 8'h00;
    end
    repeat (3) @(negedge clk);
    chk(psp == 0 && dsp == 0, "R1 pointers reset", {psp, dsp}, 0);
    chk(!int_en && !busy && !done, "R1 flags reset", {int_en, busy, done}, 0);
    chk(!ram_we && !ram_re, "R1 strobes reset", {ram_we, ram_re}, 0);
    rst_n = 1'b1;

    do_ldp(8'h10);
    chk(mem[8'h10] == 8'h00, "R8 no RAM write", mem[8'h10], 0);
    do_save(0, 14'h2A5C, 1, 0);
    do_save(1, 14'h0133, 0, 1);
    do_restore(1);
    do_restore(0);
    do_save(1, 14'h1F00, 1, 1);
    do_restore(1);

    do_ldp(8'hFF);
    do_save(0, 14'h3FFF, 1, 1);
    chk(psp == 8'h01, "R9 psp wrap up", psp, 1);
    do_restore(0);

    do_push(8'h5A);
    chk(dsp == 8'hFF, "R6 push from zero", dsp, 8'hFF);
    do_push(8'hC3);
    do_pop();
    do_pop();
    chk(dsp == 8'h00, "R9 dsp wrap", dsp, 0);

    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd4; cmd_data = 8'h77;
    @(negedge clk);
    cmd_op = 3'd5; cmd_data = 8'h11;
    @(negedge clk);
    chk(done == 1'b1, "R10 busy push done", done, 1);
    cmd_valid = 1'b0;
    smem[8'hFF] = 8'h77;
    m_dsp = 8'hFF;
    @(negedge clk);
    @(negedge clk);
    chk(dsp == 8'hFF, "R10 request while busy ignored", dsp, 8'hFF);
    chk(mem[8'hFF] == 8'h77, "R10 push data kept", mem[8'hFF], 8'h77);

    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd7;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (4) begin
      chk(!done && !busy && !ram_we, "R10 op 7 ignored", {done, busy, ram_we}, 0);
      @(negedge clk);
    end
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++;
      fails++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule